// File: doc/BRIEF.md
# Flow-Controlled Serial Byte Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Bytes are written through a valid/ready port into a small queue. The serializer drains that queue one character at a time. Bit timing comes from an external baud tick enable, and each bit lasts one tick period.

An optional hardware handshake holds transmission back while the receiving side is not ready. The clear-to-send input is active low. It is brought into the clock domain through a flop chain, and it is examined only at the point where a new character would begin. A character already on the line therefore always runs to the end of its stop bit. While the handshake holds the line, the output rests at logic 1. When the handshake is turned off, the clear-to-send input has no effect.

The write port follows valid/ready rules. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the queue is full. A byte offered while `in_ready` is low is not stored, so the writer must hold it and offer it again.

Top module: `serial_tx_flow`

## Requirements
- R1: After reset, `txd` is 1 and `in_ready` is 1.
- R2: A frame is a 0 start bit, then `in_data` bits 0 through 7 in that order, then a 1 stop bit. Each bit holds for exactly one baud tick period, and `txd` changes only on clock edges where `baud_tick` is high.
- R3: A byte is stored when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is 0 exactly while the queue holds DEPTH bytes (default 4). A byte offered while `in_ready` is 0 is discarded. Stored bytes are sent in the order they were written.
- R4: A new character can begin only on a tick while the line is idle or on the tick that ends a stop bit. Queued characters therefore follow one another with no idle bit between them.
- R5: With `flow_en` at 1, a character starts only if the `cts_n` value taken two clocks earlier through the synchronizer is 0.
- R6: If `cts_n` rises while a character is being sent, that character still completes, including its stop bit.
- R7: While `flow_en` is 1 and the synchronized `cts_n` is 1, `txd` stays at 1 for as long as the hold lasts.
- R8: After `cts_n` falls again, the next queued character starts with its start bit on the first boundary tick at which the synchronized value is 0.
- R9: With `flow_en` at 0, `cts_n` is ignored, and characters are sent whenever the queue is not empty.
- R10: While the queue is empty and no frame is in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking a bit period boundary |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Queue can take a byte (low when full) |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| flow_en | input | 1 | 1 applies the clear-to-send handshake |
| txd | output | 1 | Serial output, idles at 1 |

## Verification
The hardest case to reach from the ports is a clear-to-send edge that lands right at a character boundary. The synchronizer delay decides whether the next start bit is released or held, and a single clock of offset changes the result. The stimulus releases and re-raises `cts_n` at a sweep of clock offsets relative to the tick train, with characters waiting in the queue. A cycle-by-cycle model of the queue, the synchronizer and the bit position then predicts every edge of `txd`. A separate step drops `cts_n` in the middle of a frame to show that the frame still completes before the line stalls.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] tx_byte_t;

  function automatic int pos_width(input int data_bits);
    return $clog2(data_bits + 3);
  endfunction
endpackage

// File: rtl/tx_sync_chain.sv
module tx_sync_chain #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int AW    = 2,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      level <= level + LW'(wr_en) - LW'(rd_en);
    end
  end

  assign rd_data = store[rd_ptr];
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int W  = 8,
  parameter int PW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         can_send,
  input  logic [W-1:0] byte_in,
  output logic         pop,
  output logic         txd,
  output logic         busy
);
  // position: 0 idle, 1 start, 2..W+1 data, W+2 stop on line
  localparam int STOP_POS = W + 1;
  localparam int LAST_POS = W + 2;

  logic [PW-1:0] pos;
  logic [W-1:0]  shreg;
  logic          at_boundary;

  assign at_boundary = (pos == '0) || (pos == PW'(LAST_POS));
  assign pop         = tick && at_boundary && can_send;
  assign busy        = (pos != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      txd   <= 1'b1;
      shreg <= '0;
    end else if (tick) begin
      if (at_boundary) begin
        if (can_send) begin
          pos   <= PW'(1);
          txd   <= 1'b0;
          shreg <= byte_in;
        end else begin
          pos <= '0;
          txd <= 1'b1;
        end
      end else if (pos < PW'(STOP_POS)) begin
        txd   <= shreg[0];
        shreg <= shreg >> 1;
        pos   <= pos + PW'(1);
      end else begin
        txd <= 1'b1;
        pos <= PW'(LAST_POS);
      end
    end
  end
endmodule

// File: rtl/serial_tx_flow.sv
module serial_tx_flow #(
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       baud_tick,
  input  logic [serial_tx_pkg::BYTE_W-1:0] in_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       cts_n,
  input  logic                       flow_en,
  output logic                       txd
);
  import serial_tx_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = pos_width(BYTE_W);

  logic          cts_n_sync;
  logic          fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [LW-1:0] fifo_level;
  tx_byte_t      head_byte;
  logic          can_send, ser_busy;

  tx_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_n), .sync_out(cts_n_sync)
  );

  assign in_ready  = !fifo_full;
  assign fifo_push = in_valid && in_ready;

  tx_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W), .AW(AW), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_push), .wr_data(in_data),
    .rd_en(fifo_pop), .rd_data(head_byte), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign can_send = !fifo_empty && (!flow_en || !cts_n_sync);

  tx_frame_shifter #(.W(BYTE_W), .PW(PW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .can_send(can_send),
    .byte_in(head_byte), .pop(fifo_pop), .txd(txd), .busy(ser_busy)
  );
endmodule

// File: rtl/serial_tx_flow_chk.sv
module serial_tx_flow_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          flow_en,
  input logic          cts_sync,
  input logic          pop,
  input logic          busy,
  input logic          txd,
  input logic [LW-1:0] level
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> txd == $past(txd));

  assert_pop_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> baud_tick);

  assert_start_follows_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !txd);

  assert_flow_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && flow_en) |-> !cts_sync);

  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
endmodule

bind serial_tx_flow serial_tx_flow_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .flow_en(flow_en),
  .cts_sync(cts_n_sync), .pop(fifo_pop), .busy(ser_busy), .txd(txd),
  .level(fifo_level)
);

// File: tb/test_serial_tx_flow.sv
`timescale 1ns/1ps
module test_serial_tx_flow;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0, baud_tick = 0, in_valid = 0, cts_n = 1, flow_en = 0;
  logic [7:0] in_data = '0;
  logic in_ready, txd;

  int tests = 0, fails = 0;
  string tag = "R1";
  bit done = 0;
  int tick_div = 4;

  serial_tx_flow #(.DEPTH(DEPTH)) i_serial_tx_flow (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cts_n(cts_n),
    .flow_en(flow_en), .txd(txd)
  );

  always #5 clk = ~clk;

  // baud tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    if (tcnt + 1 >= tick_div) begin tcnt = 0; baud_tick = 1; end
    else begin tcnt = tcnt + 1; baud_tick = 0; end
  end

  // behavioural reference model
  byte unsigned q[$];
  logic [7:0] cur;
  int  mpos = 0;
  logic mtx = 1, s1 = 1, s2 = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); mpos = 0; mtx = 1; s1 = 1; s2 = 1;
    end else begin
      automatic bit take = in_valid && (q.size() < DEPTH);
      if (baud_tick) begin
        if (mpos == 0 || mpos == 10) begin
          if (q.size() > 0 && (!flow_en || s2 == 0)) begin
            cur = q.pop_front(); mpos = 1; mtx = 0;
          end else begin
            mpos = 0; mtx = 1;
          end
        end else if (mpos <= 8) begin
          mtx = cur[mpos-1]; mpos = mpos + 1;
        end else begin
          mtx = 1; mpos = 10;
        end
      end
      if (take) q.push_back(in_data);
      s2 = s1; s1 = cts_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (txd !== mtx) begin
        fails++;
        $display("FAIL %s txd: actual=%b expected=%b at %0t", tag, txd, mtx, $time);
      end
      tests++;
      if (in_ready !== (q.size() < DEPTH)) begin
        fails++;
        $display("FAIL %s in_ready: actual=%b expected=%b", tag, in_ready, q.size() < DEPTH);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); in_valid = 1; in_data = b;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic hold_high(input string req, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    tests++;
    if (lows != 0) begin
      fails++;
      $display("FAIL %s: actual=%0d low cycles expected=0", req, lows);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 txd", txd, 1'b1);
    check("R1 in_ready", in_ready, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1 txd after release", txd, 1'b1);

    // R9, R2, R4: flow control off, cts deasserted, back-to-back frames
    tag = "R9";
    flow_en = 0; cts_n = 1;
    push(8'hA5); push(8'h3C); push(8'h01);
    tag = "R2";
    repeat (150) @(negedge clk);

    // irregular tick rate, R4 back-to-back
    tag = "R4";
    tick_div = 3;
    push(8'h96); push(8'h5A);
    repeat (80) @(negedge clk);
    tick_div = 4;

    // R5, R7, R3: hold with cts high, fill queue
    tag = "R5";
    flow_en = 1; cts_n = 1;
    repeat (5) @(negedge clk);
    push(8'h81); push(8'h7E); push(8'hFF); push(8'h00);
    tag = "R3";
    check("R3 full", in_ready, 1'b0);
    push(8'h55);
    check("R3 still full", in_ready, 1'b0);
    tag = "R7";
    hold_high("R7 stall", 100);

    // R8 resume, R6 deassert mid-frame
    tag = "R8";
    cts_n = 0;
    repeat (20) @(negedge clk);
    tag = "R6";
    cts_n = 1;
    repeat (80) @(negedge clk);

    // sweep release offsets around tick boundary
    tag = "R8";
    for (int k = 0; k < 6; k++) begin
      repeat (k) @(negedge clk);
      cts_n = 0;
      repeat (3 + k) @(negedge clk);
      cts_n = 1;
      repeat (50) @(negedge clk);
    end
    push(8'hC3); push(8'h18);
    cts_n = 0;
    repeat (250) @(negedge clk);

    // R10: empty and idle
    tag = "R10";
    hold_high("R10 idle", 60);
    check("R10 ready", in_ready, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule